// File: doc/BRIEF.md
# Windowed Dual-Clock VGA Framebuffer

This block takes pixels from an external video source, running on its own slow capture clock, and stores them in on-chip memory. A VGA raster generator on an unrelated display clock reads that memory back. Each incoming pixel carries 6 bits per colour, 18 bits in all. The capture path keeps the top bits of each colour and stores the pixel as one 3-3-2 byte. The two clocks share nothing except the memory. The capture side owns its write port and the display side owns its read port, so no handshake crosses between the domains.

The stored picture is a fixed window of `WIN_W` x `WIN_H` pixels at the top-left corner of the visible raster. Every other position, blanking included, is driven black. The intended build is a 256 x 192 window, which needs 49152 bytes, inside a 640 x 480 frame with a 25 MHz display clock. Capture runs at about 5.6 MHz in that build. The parameter defaults give a smaller window so that default elaboration stays light.

The capture input is a valid/ready stream with a start-of-frame flag carried alongside valid. The block never applies back-pressure: `cap_ready` is held high, and every beat is taken on the capture clock edge where `cap_valid` is high. When the window is full, beats are accepted and discarded until the next start-of-frame.

Top module: `vga_window_fb`

## Requirements
- R1: The stored byte is red = `cap_pix[17:15]`, green = `cap_pix[11:9]`, blue = `cap_pix[5:4]`. Red sits in `cap_pix[17:12]`, green in `cap_pix[11:6]` and blue in `cap_pix[5:0]`. The lower bits are dropped, with no rounding.
- R2: On the `DAC_W`=4 outputs, a 3-bit colour `c2 c1 c0` is driven as `c2 c1 c0 c2` and the 2-bit blue `b1 b0` as `b1 b0 b1 b0`.
- R3: At visible position (x, y) with x < `WIN_W` and y < `WIN_H`, the colour outputs show the byte stored at address y*`WIN_W`+x. It appears in the same cycle as that position's sync levels.
- R4: At every raster position outside the window, including horizontal and vertical blanking, all colour outputs are zero.
- R5: Each accepted beat without start-of-frame is written at the current capture address, and the address then advances by one. After reset the capture address is 0.
- R6: While `vga_rst_n` is low, `vga_hs_n` and `vga_vs_n` are high and all colour outputs are zero.
- R7: Each line is `H_VIS+H_FP+H_SYNC+H_BP` clocks long. `vga_hs_n` is low exactly at columns `H_VIS+H_FP` through `H_VIS+H_FP+H_SYNC-1`.
- R8: Each frame is `V_VIS+V_FP+V_SYNC+V_BP` lines long. `vga_vs_n` is low for all of lines `V_VIS+V_FP` through `V_VIS+V_FP+V_SYNC-1`.
- R9: After `WIN_W*WIN_H` writes, further beats without start-of-frame change no stored pixel.
- R10: A beat with `cap_sof` high is written at address 0, and the next beat goes to address 1. This holds whether or not the window was full.
- R11: `cap_ready` is high whenever `cap_rst_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cap_clk | input | 1 | Capture clock from the video source |
| cap_rst_n | input | 1 | Active-low synchronous reset, capture domain |
| cap_valid | input | 1 | Stream valid for `cap_pix` |
| cap_sof | input | 1 | Start-of-frame flag, qualified by `cap_valid` |
| cap_pix | input | 18 | Pixel: red [17:12], green [11:6], blue [5:0] |
| cap_ready | output | 1 | Stream ready, held high |
| vga_clk | input | 1 | Display pixel clock |
| vga_rst_n | input | 1 | Active-low synchronous reset, display domain |
| vga_r | output | DAC_W | Red DAC value |
| vga_g | output | DAC_W | Green DAC value |
| vga_b | output | DAC_W | Blue DAC value |
| vga_hs_n | output | 1 | Horizontal sync, active low |
| vga_vs_n | output | 1 | Vertical sync, active low |

## Verification
The assertions assume that `cap_sof` and `cap_pix` are known whenever `cap_valid` is high. They also assume that `H_SYNC` is at least two clocks and that the window fits inside the visible area. The block has no protection for a display read of an address in the same cycle that the capture side writes it. The stimulus therefore finishes every batch of capture beats before it starts scanning a frame. As a result, every pixel compared on the display side was stored well before it is read. The bench shortens the raster timings and the window so that a whole frame, blanking included, can be compared position by position.

// File: rtl/fb_pkg.sv
package fb_pkg;
  typedef struct packed {
    logic [2:0] r;
    logic [2:0] g;
    logic [1:0] b;
  } rgb332_t;

  // Keep the top bits of each 6-bit colour field; truncation, no rounding.
  function automatic rgb332_t reduce666(input logic [17:0] px);
    rgb332_t o;
    o.r = px[17:15];
    o.g = px[11:9];
    o.b = px[5:4];
    return o;
  endfunction
endpackage

// File: rtl/fb_capture.sv
module fb_capture #(
  parameter int DEPTH = 3072,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic               in_sof,
  input  logic [17:0]        in_pix,
  output logic               wr_en,
  output logic [AW-1:0]      wr_addr,
  output fb_pkg::rgb332_t    wr_data
);
  logic [AW-1:0] addr_q;
  logic          full_q;

  always_comb begin
    wr_en   = in_valid && (in_sof || !full_q);
    wr_addr = in_sof ? '0 : addr_q;
    wr_data = fb_pkg::reduce666(in_pix);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      full_q <= 1'b0;
    end else if (wr_en) begin
      if (wr_addr == AW'(DEPTH - 1)) begin
        addr_q <= '0;
        full_q <= 1'b1;
      end else begin
        addr_q <= wr_addr + 1'b1;
        full_q <= 1'b0;
      end
    end
  end

  p_addr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_sof && !full_q && addr_q != AW'(DEPTH - 1))
      |=> (addr_q == $past(addr_q) + 1'b1));

  p_full_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !(in_valid && in_sof)) |=> (full_q && $stable(addr_q)));

  p_sof_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sof) |=> (addr_q == AW'(1)));
endmodule

// File: rtl/fb_ram.sv
module fb_ram #(
  parameter int DEPTH = 3072,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/fb_expand.sv
module fb_expand #(
  parameter int IN_W  = 3,
  parameter int OUT_W = 4
) (
  input  logic [IN_W-1:0]  din,
  output logic [OUT_W-1:0] dout
);
  for (genvar k = 0; k < OUT_W; k++) begin : g_bit
    assign dout[OUT_W-1-k] = din[IN_W-1-(k % IN_W)];
  end
endmodule

// File: rtl/vga_timing.sv
module vga_timing #(
  parameter int H_VIS = 640, parameter int H_FP = 16, parameter int H_SYNC = 96, parameter int H_BP = 48,
  parameter int V_VIS = 480, parameter int V_FP = 10, parameter int V_SYNC = 2,  parameter int V_BP = 33,
  localparam int H_TOT = H_VIS + H_FP + H_SYNC + H_BP,
  localparam int V_TOT = V_VIS + V_FP + V_SYNC + V_BP,
  localparam int HCW = $clog2(H_TOT),
  localparam int VCW = $clog2(V_TOT)
) (
  input  logic           clk,
  input  logic           rst_n,
  output logic [HCW-1:0] hcnt,
  output logic [VCW-1:0] vcnt,
  output logic           hs_n,
  output logic           vs_n
);
  localparam int HS_BEG = H_VIS + H_FP;
  localparam int VS_BEG = V_VIS + V_FP;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hcnt <= '0;
      vcnt <= '0;
    end else if (hcnt == HCW'(H_TOT - 1)) begin
      hcnt <= '0;
      vcnt <= (vcnt == VCW'(V_TOT - 1)) ? '0 : vcnt + 1'b1;
    end else begin
      hcnt <= hcnt + 1'b1;
    end
  end

  always_comb begin
    hs_n = !(hcnt >= HCW'(HS_BEG) && hcnt < HCW'(HS_BEG + H_SYNC));
    vs_n = !(vcnt >= VCW'(VS_BEG) && vcnt < VCW'(VS_BEG + V_SYNC));
  end

  p_hwrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hcnt == HCW'(H_TOT - 1)) |=> (hcnt == '0));

  p_vhold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hcnt != HCW'(H_TOT - 1)) |=> $stable(vcnt));
endmodule

// File: rtl/vga_window_fb.sv
module vga_window_fb #(
  parameter int WIN_W = 64,
  parameter int WIN_H = 48,
  parameter int DAC_W = 4,
  parameter int H_VIS = 640, parameter int H_FP = 16, parameter int H_SYNC = 96, parameter int H_BP = 48,
  parameter int V_VIS = 480, parameter int V_FP = 10, parameter int V_SYNC = 2,  parameter int V_BP = 33
) (
  input  logic             cap_clk,
  input  logic             cap_rst_n,
  input  logic             cap_valid,
  input  logic             cap_sof,
  input  logic [17:0]      cap_pix,
  output logic             cap_ready,
  input  logic             vga_clk,
  input  logic             vga_rst_n,
  output logic [DAC_W-1:0] vga_r,
  output logic [DAC_W-1:0] vga_g,
  output logic [DAC_W-1:0] vga_b,
  output logic             vga_hs_n,
  output logic             vga_vs_n
);
  localparam int DEPTH = WIN_W * WIN_H;
  localparam int AW    = $clog2(DEPTH);
  localparam int HCW   = $clog2(H_VIS + H_FP + H_SYNC + H_BP);
  localparam int VCW   = $clog2(V_VIS + V_FP + V_SYNC + V_BP);

  // Capture domain
  logic            wr_en;
  logic [AW-1:0]   wr_addr;
  fb_pkg::rgb332_t wr_data;

  assign cap_ready = 1'b1;

  fb_capture #(.DEPTH(DEPTH)) u_cap (
    .clk(cap_clk), .rst_n(cap_rst_n), .in_valid(cap_valid), .in_sof(cap_sof),
    .in_pix(cap_pix), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  // Display domain
  logic [HCW-1:0]  hcnt;
  logic [VCW-1:0]  vcnt;
  logic            hs_raw, vs_raw, in_win;
  logic [AW-1:0]   rd_addr;
  fb_pkg::rgb332_t rd_data;
  logic            win_q, hs_q, vs_q;

  vga_timing #(
    .H_VIS(H_VIS), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_VIS(V_VIS), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP)
  ) u_tim (
    .clk(vga_clk), .rst_n(vga_rst_n), .hcnt(hcnt), .vcnt(vcnt), .hs_n(hs_raw), .vs_n(vs_raw)
  );

  always_comb begin
    in_win  = (hcnt < HCW'(WIN_W)) && (vcnt < VCW'(WIN_H));
    rd_addr = AW'(int'(vcnt) * WIN_W + int'(hcnt));
  end

  fb_ram #(.DEPTH(DEPTH), .DW(8)) u_ram (
    .wclk(cap_clk), .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
    .rclk(vga_clk), .re(in_win), .raddr(rd_addr), .rdata(rd_data)
  );

  // Align the window flag and syncs with the one-cycle memory read.
  always_ff @(posedge vga_clk) begin
    if (!vga_rst_n) begin
      win_q <= 1'b0;
      hs_q  <= 1'b1;
      vs_q  <= 1'b1;
    end else begin
      win_q <= in_win;
      hs_q  <= hs_raw;
      vs_q  <= vs_raw;
    end
  end

  logic [DAC_W-1:0] r_x, g_x, b_x;
  fb_expand #(.IN_W(3), .OUT_W(DAC_W)) u_xr (.din(rd_data.r), .dout(r_x));
  fb_expand #(.IN_W(3), .OUT_W(DAC_W)) u_xg (.din(rd_data.g), .dout(g_x));
  fb_expand #(.IN_W(2), .OUT_W(DAC_W)) u_xb (.din(rd_data.b), .dout(b_x));

  always_comb begin
    vga_r    = win_q ? r_x : '0;
    vga_g    = win_q ? g_x : '0;
    vga_b    = win_q ? b_x : '0;
    vga_hs_n = hs_q;
    vga_vs_n = vs_q;
  end

  p_hs_black_r4: assert property (@(posedge vga_clk) disable iff (!vga_rst_n)
    !vga_hs_n |-> (vga_r == '0 && vga_g == '0 && vga_b == '0));

  p_vs_black_r8: assert property (@(posedge vga_clk) disable iff (!vga_rst_n)
    !vga_vs_n |-> (vga_r == '0 && vga_g == '0 && vga_b == '0));

  p_hs_width_r7: assert property (@(posedge vga_clk) disable iff (!vga_rst_n)
    $fell(vga_hs_n) |=> !vga_hs_n);
endmodule

// File: tb/sim_vga_window_fb.sv
module sim_vga_window_fb;
  localparam int WW = 16, WH = 8, DEP = WW * WH;
  localparam int HV = 40, HF = 4, HS = 6, HB = 6, HT = HV + HF + HS + HB;
  localparam int VV = 30, VF = 2, VS = 2, VB = 3, VT = VV + VF + VS + VB;

  logic cap_clk = 0, vga_clk = 0;
  logic cap_rst_n = 0, vga_rst_n = 0;
  logic cap_valid = 0, cap_sof = 0;
  logic [17:0] cap_pix = '0;
  logic cap_ready, hs_n, vs_n;
  logic [3:0] vr, vg, vb;

  always #10 vga_clk = ~vga_clk;
  always #37 cap_clk = ~cap_clk;

  vga_window_fb #(
    .WIN_W(WW), .WIN_H(WH), .DAC_W(4),
    .H_VIS(HV), .H_FP(HF), .H_SYNC(HS), .H_BP(HB),
    .V_VIS(VV), .V_FP(VF), .V_SYNC(VS), .V_BP(VB)
  ) u0 (
    .cap_clk(cap_clk), .cap_rst_n(cap_rst_n), .cap_valid(cap_valid), .cap_sof(cap_sof),
    .cap_pix(cap_pix), .cap_ready(cap_ready), .vga_clk(vga_clk), .vga_rst_n(vga_rst_n),
    .vga_r(vr), .vga_g(vg), .vga_b(vb), .vga_hs_n(hs_n), .vga_vs_n(vs_n)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  logic [17:0] model [DEP];
  int m_addr = 0;
  bit m_full = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R1 truncation followed by R2 bit repetition, written from the requirement text.
  function automatic int exp_rgb(input logic [17:0] px);
    return int'({px[17:15], px[17], px[11:9], px[11], px[5:4], px[5:4]});
  endfunction

  function automatic logic [17:0] pat(input int a, input int seed);
    logic [17:0] v;
    if (a == 0) return 18'h3FFFF;       // full scale -> all ones
    if (a == 1) return 18'h071C7;       // only low bits set -> black (R1)
    if (a == 2) return 18'h38030;       // red and blue top bits only
    v = 18'(a * 5923 + seed * 7717 + 1234);
    return v;
  endfunction

  task automatic beat(input logic [17:0] px, input bit sof);
    @(negedge cap_clk);
    chk("R11 ready", int'(cap_ready), 1);
    cap_valid = 1; cap_sof = sof; cap_pix = px;
    @(negedge cap_clk);
    cap_valid = 0; cap_sof = 0;
    // requirement model: R5, R9, R10
    if (sof) begin
      model[0] = px; m_addr = 1; m_full = 0;
    end else if (!m_full) begin
      model[m_addr] = px;
      if (m_addr == DEP - 1) begin m_full = 1; m_addr = 0; end
      else m_addr++;
    end
  endtask

  task automatic scan_frame(input string win_tag);
    @(negedge vga_clk);
    while (vs_n !== 1'b1) @(negedge vga_clk);
    while (vs_n !== 1'b0) @(negedge vga_clk);
    repeat (VT * HT - (VV + VF) * HT) @(negedge vga_clk);
    for (int v = 0; v < VT; v++) begin
      for (int h = 0; h < HT; h++) begin
        bit ehs, evs, inw;
        ehs = !(h >= HV + HF && h < HV + HF + HS);
        evs = !(v >= VV + VF && v < VV + VF + VS);
        inw = (h < WW) && (v < WH);
        chk("R7 hsync", int'(hs_n), int'(ehs));
        chk("R8 vsync", int'(vs_n), int'(evs));
        if (inw) chk(win_tag, int'({vr, vg, vb}), exp_rgb(model[v * WW + h]));
        else     chk("R4 outside black", int'({vr, vg, vb}), 0);
        @(negedge vga_clk);
      end
    end
  endtask

  task automatic t_reset;
    repeat (5) @(negedge vga_clk);
    chk("R6 hs in reset", int'(hs_n), 1);
    chk("R6 vs in reset", int'(vs_n), 1);
    chk("R6 colour in reset", int'({vr, vg, vb}), 0);
    @(negedge cap_clk); cap_rst_n = 1;
    @(negedge vga_clk); vga_rst_n = 1;
    @(negedge cap_clk);
    chk("R11 ready after reset", int'(cap_ready), 1);
  endtask

  // R1 R2 R3 R5: full window filled in raster order, checked at every position.
  task automatic t_fill;
    for (int a = 0; a < DEP; a++) beat(pat(a, 0), a == 0);
    scan_frame("R1 R2 R3 R5 window pixel");
  endtask

  // R9: extra beats after a full window change nothing, address 0 included.
  task automatic t_overflow;
    for (int a = 0; a < 6; a++) beat(18'h2AAAA ^ 18'(a), 1'b0);
    scan_frame("R9 window after overflow");
  endtask

  // R10: start-of-frame restarts the address at 0 even when full.
  task automatic t_restart;
    for (int a = 0; a < 4; a++) beat(pat(a + 7, 3), a == 0);
    scan_frame("R10 window after restart");
  endtask

  initial begin
    int n = 0;
    while (!done) begin
      @(posedge vga_clk);
      n++;
      if (n > 150000 && !done) begin
        errors++;
        $display("FAIL watchdog all requirements actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    t_reset();
    t_fill();
    t_overflow();
    t_restart();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule